// File: doc/BRIEF.md
# Row-Column 2D FFT Address Sequencer

This block drives an in-place radix-2 decimation-in-time two-dimensional transform of an N×N matrix that sits in a dual-port RAM. It issues one butterfly per clock. For each butterfly it gives two matrix addresses, which serve as both the operand read locations and the result write locations, and a twiddle-table address. The butterfly datapath, the RAM and the twiddle table sit outside the block and consume this stream.

A pass begins on a start pulse. The block first runs a complete 1D transform on each row, then a complete 1D transform on each column. A one-cycle done pulse marks the end of the pass. A forward/inverse selector is captured at start and passed along with every butterfly, so that the arithmetic can conjugate the twiddle. Operands are expected in bit-reversed order along the dimension being transformed.

Top module: `fft2d_addr_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `bf_valid` and `done` are low.
- R2: A matrix address is `{row, col}`: the row in the upper LOG2N bits and the column in the lower LOG2N bits. In the row phase (`col_phase`=0) the row field holds the line number and the column field holds the point index. In the column phase (`col_phase`=1) the two fields swap roles.
- R3: The issue order is as follows. All rows come first (line 0 to N-1), then all columns. Inside each line, stages run from 0 to LOG2N-1. Inside each stage, butterfly number b counts up from 0 to N/2-1. `stage_out` reports the stage.
- R4: A start accepted at clock edge E0 produces the first valid butterfly right after edge E1. `bf_valid` then stays high for exactly N·N·LOG2N/2·2/N·N… that is, for N²·LOG2N/2 row butterflies followed by the same number of column butterflies, with no gap. `busy` is high from E0 until the last butterfly is issued.
- R5: For butterfly b in stage s, take j = b mod 2^s and g = b div 2^s. The point indices are a = g·2^(s+1) + j and a + 2^s, placed on `addr_a` and `addr_b` respectively.
- R6: `tw_addr` = j·N/2^(s+1), with j as in R5.
- R7: `done` is high for exactly one cycle: the cycle right after the final column-phase butterfly is shown.
- R8: `inv_out` equals the `op_inv` value captured when start was accepted, and stays unchanged for the whole pass.
- R9: A start that arrives while `busy` is high is ignored. The address sequence and `inv_out` continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a 2D pass when idle |
| op_inv | input | 1 | 1 = inverse transform, sampled at start |
| busy | output | 1 | Pass in progress |
| bf_valid | output | 1 | Butterfly outputs valid this cycle |
| addr_a | output | 2*LOG2N | Matrix address of the lower point of the pair |
| addr_b | output | 2*LOG2N | Matrix address of the upper point of the pair |
| tw_addr | output | LOG2N-1 | Twiddle table index |
| inv_out | output | 1 | Direction bit passed on to the arithmetic |
| col_phase | output | 1 | 0 = row phase, 1 = column phase |
| stage_out | output | SW | Current stage number |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
On an 8×8 configuration, the bench follows every butterfly of full passes in both directions. It compares each address pair, twiddle index and stage against values worked out from the stage, group and pair formulas. Because every row and every column is covered, a fault that swaps the row and column fields, steps the lines or stages in the wrong order, or produces a bad pair distance or twiddle scale all show up. A second start, carrying the opposite direction bit, is injected partway through a pass. This shows whether a start during a pass restarts the counters or alters the direction, as opposed to being ignored. The cycles around each pass boundary test the start latency and the exact position of the done pulse.

// File: rtl/fft2d_seq_pkg.sv
package fft2d_seq_pkg;
  typedef enum logic {
    PH_ROW = 1'b0,
    PH_COL = 1'b1
  } sweep_phase_e;
endpackage

// File: rtl/fft2d_sweep_ctr.sv
module fft2d_sweep_ctr
  import fft2d_seq_pkg::*;
#(
  parameter int LOG2N = 8,
  localparam int SW = (LOG2N > 1) ? $clog2(LOG2N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output sweep_phase_e     phase,
  output logic [LOG2N-1:0] line,
  output logic [SW-1:0]    stage,
  output logic [LOG2N-2:0] bfly,
  output logic             last
);
  logic bfly_end, stage_end, line_end;

  assign bfly_end  = &bfly;
  assign stage_end = (stage == SW'(LOG2N - 1));
  assign line_end  = &line;
  assign last      = bfly_end && stage_end && line_end && (phase == PH_COL);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase <= PH_ROW;
      line  <= '0;
      stage <= '0;
      bfly  <= '0;
    end else if (step) begin
      bfly <= bfly + 1'b1;
      if (bfly_end) begin
        if (stage_end) begin
          stage <= '0;
          line  <= line + 1'b1;
          if (line_end) phase <= PH_COL;
        end else begin
          stage <= stage + 1'b1;
        end
      end
    end
  end

  p_stage_range_r3: assert property (@(posedge clk) disable iff (rst)
    stage <= SW'(LOG2N - 1));
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_COL) && !clear |=> phase == PH_COL);
endmodule

// File: rtl/fft2d_bfly_addr.sv
module fft2d_bfly_addr #(
  parameter int LOG2N = 8,
  localparam int SW = (LOG2N > 1) ? $clog2(LOG2N) : 1
) (
  input  logic [SW-1:0]    stage,
  input  logic [LOG2N-2:0] bfly,
  output logic [LOG2N-1:0] idx_a,
  output logic [LOG2N-1:0] idx_b,
  output logic [LOG2N-2:0] tw
);
  logic [LOG2N-1:0] b_ext, span, mask, pos, grp_base, tw_full;
  logic [SW-1:0]    tw_sh;

  always_comb begin
    b_ext    = {1'b0, bfly};
    span     = LOG2N'(1) << stage;
    mask     = span - 1'b1;
    pos      = b_ext & mask;
    grp_base = (b_ext & ~mask) << 1;
    idx_a    = grp_base | pos;
    idx_b    = idx_a | span;
    tw_sh    = SW'(LOG2N - 1) - stage;
    tw_full  = pos << tw_sh;
    tw       = tw_full[LOG2N-2:0];
  end
endmodule

// File: rtl/fft2d_addr_seq.sv
module fft2d_addr_seq
  import fft2d_seq_pkg::*;
#(
  parameter int LOG2N = 8,
  localparam int AW = 2 * LOG2N,
  localparam int TW = LOG2N - 1,
  localparam int SW = (LOG2N > 1) ? $clog2(LOG2N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_inv,
  output logic          busy,
  output logic          bf_valid,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [TW-1:0] tw_addr,
  output logic          inv_out,
  output logic          col_phase,
  output logic [SW-1:0] stage_out,
  output logic          done
);
  sweep_phase_e     phase;
  logic [LOG2N-1:0] line, idx_a, idx_b;
  logic [SW-1:0]    stage;
  logic [LOG2N-2:0] bfly, tw;
  logic             ctr_last, run_q, inv_q, last_q, accept;

  assign accept = start && !run_q;
  assign busy   = run_q;

  fft2d_sweep_ctr #(.LOG2N(LOG2N)) u_ctr (
    .clk(clk), .rst(rst), .clear(accept), .step(run_q),
    .phase(phase), .line(line), .stage(stage), .bfly(bfly), .last(ctr_last)
  );

  fft2d_bfly_addr #(.LOG2N(LOG2N)) u_addr (
    .stage(stage), .bfly(bfly), .idx_a(idx_a), .idx_b(idx_b), .tw(tw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      inv_q     <= 1'b0;
      bf_valid  <= 1'b0;
      last_q    <= 1'b0;
      done      <= 1'b0;
      addr_a    <= '0;
      addr_b    <= '0;
      tw_addr   <= '0;
      inv_out   <= 1'b0;
      col_phase <= 1'b0;
      stage_out <= '0;
    end else begin
      if (accept) begin
        run_q <= 1'b1;
        inv_q <= op_inv;
      end else if (run_q && ctr_last) begin
        run_q <= 1'b0;
      end
      bf_valid <= run_q;
      done     <= bf_valid && last_q;
      if (run_q) begin
        last_q    <= ctr_last;
        inv_out   <= inv_q;
        tw_addr   <= tw;
        stage_out <= stage;
        col_phase <= (phase == PH_COL);
        if (phase == PH_COL) begin
          addr_a <= {idx_a, line};
          addr_b <= {idx_b, line};
        end else begin
          addr_a <= {line, idx_a};
          addr_b <= {line, idx_b};
        end
      end
    end
  end

  p_pair_one_bit_r5: assert property (@(posedge clk) disable iff (rst)
    bf_valid |-> $countones(addr_a ^ addr_b) == 1);
  p_row_shared_r2: assert property (@(posedge clk) disable iff (rst)
    bf_valid && !col_phase |-> addr_a[AW-1:LOG2N] == addr_b[AW-1:LOG2N]);
  p_col_shared_r2: assert property (@(posedge clk) disable iff (rst)
    bf_valid && col_phase |-> addr_a[LOG2N-1:0] == addr_b[LOG2N-1:0]);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_valid_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bf_valid) && $past(col_phase));
  p_inv_stable_r8: assert property (@(posedge clk) disable iff (rst)
    bf_valid && $past(bf_valid) |-> $stable(inv_out));
endmodule

// File: tb/fft2d_addr_seq_tb.sv
module fft2d_addr_seq_tb;
  localparam int L  = 3;
  localparam int N  = 1 << L;
  localparam int AW = 2 * L;
  localparam int SW = 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, op_inv = 1'b0;
  logic busy, bf_valid, inv_out, col_phase, done;
  logic [AW-1:0] addr_a, addr_b;
  logic [L-2:0]  tw_addr;
  logic [SW-1:0] stage_out;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  fft2d_addr_seq #(.LOG2N(L)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_inv(op_inv), .busy(busy),
    .bf_valid(bf_valid), .addr_a(addr_a), .addr_b(addr_b), .tw_addr(tw_addr),
    .inv_out(inv_out), .col_phase(col_phase), .stage_out(stage_out), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_pass(input bit inv, input bit inject);
    int k = 0;
    @(negedge clk); start = 1'b1; op_inv = inv;
    @(negedge clk); start = 1'b0; op_inv = 1'b0;
    chk(busy == 1'b1, "R4 busy after start", busy, 1);
    chk(bf_valid == 1'b0, "R4 no valid before E1", bf_valid, 0);
    for (int ph = 0; ph < 2; ph++)
      for (int ln = 0; ln < N; ln++)
        for (int s = 0; s < L; s++)
          for (int b = 0; b < N / 2; b++) begin
            int j, g, i0, i1, tw, ea, eb;
            @(negedge clk);
            start = 1'b0;
            j  = b % (1 << s);
            g  = b >> s;
            i0 = g * (2 << s) + j;
            i1 = i0 + (1 << s);
            tw = j * (N >> (s + 1));
            ea = ph ? ((i0 << L) | ln) : ((ln << L) | i0);
            eb = ph ? ((i1 << L) | ln) : ((ln << L) | i1);
            chk(bf_valid == 1'b1, "R4 valid", bf_valid, 1);
            chk(addr_a == AW'(ea), "R5 R2 addr_a", addr_a, ea);
            chk(addr_b == AW'(eb), "R5 R2 addr_b", addr_b, eb);
            chk(int'(tw_addr) == tw, "R6 twiddle", tw_addr, tw);
            chk(int'(stage_out) == s, "R3 stage", stage_out, s);
            chk(col_phase == ph[0], "R3 phase", col_phase, ph);
            chk(inv_out == inv, "R8 inv", inv_out, inv);
            chk(done == 1'b0, "R7 no early done", done, 0);
            if (inject && k == 50) begin
              chk(busy == 1'b1, "R9 busy at inject", busy, 1);
              start = 1'b1; op_inv = ~inv;
            end
            k++;
          end
    @(negedge clk);
    chk(done == 1'b1, "R7 done pulse", done, 1);
    chk(bf_valid == 1'b0, "R4 valid ends", bf_valid, 0);
    chk(busy == 1'b0, "R4 busy ends", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    chk(bf_valid == 1'b0, "R9 no restart from ignored start", bf_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(bf_valid == 1'b0, "R1 valid reset", bf_valid, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    run_pass(1'b0, 1'b1);
    run_pass(1'b1, 1'b0);
    run_pass(1'b1, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule